// File: doc/BRIEF.md
# SPI NOR Flash Block Writer

This block stores a block of bytes in serial NOR flash through its own SPI master port (mode 0), with no help from software. A client starts a block with its length. The block keeps a running write pointer that starts at zero after reset. It fetches each data byte by index through a combinational byte port, and it produces the full command stream the flash needs.

The stream covers four things:
- A write-enable frame is sent before every erase and every program.
- A sector erase is issued whenever the pointer lands on a sector start.
- Program commands are split so that none crosses a page.
- The status register is polled after every erase or program until the device reports idle.

A separate read path takes an address and a length. It streams the stored bytes back out one at a time with a valid strobe. Page size, sector size and flash capacity are parameters. Their defaults are 256 bytes, 4096 bytes and 0x400000 bytes. The address field on the wire is always 24 bits, sent most significant byte first.

Top module: `sfw_block_writer`

## Requirements
- R1: Every sector erase and every page program is preceded by a frame of its own that holds only the write-enable opcode 0x06.
- R2: A program frame is opcode 0x02, then the 24-bit address most significant byte first, then data. Each frame carries min(bytes left in block, bytes left in current page) bytes, so no frame crosses a page boundary.
- R3: A sector erase (opcode 0x20 plus 24-bit address) is issued exactly when the address about to be programmed is a multiple of SECTOR_BYTES, and before any program at that address. No erase is issued elsewhere.
- R4: After each erase or program, status frames (opcode 0x05 followed by one read byte) repeat until bit 0 of the returned byte is 0. No other command is issued while the last status showed busy.
- R5: The write pointer is 0 after reset. Each accepted block starts at the pointer, and the pointer then advances by the block length. A zero-length block completes at once with no SPI frame.
- R6: A block for which pointer + length exceeds FLASH_BYTES is rejected. The rejection gives a one-cycle `full` pulse, produces no SPI frame, and leaves the pointer unchanged. A block that ends exactly at FLASH_BYTES is accepted.
- R7: A read sends opcode 0x03 plus the 24-bit address, then outputs `rd_len` bytes in address order on `rd_data`, each with a one-cycle `rd_valid`.
- R8: Chip select stays high for at least two clock cycles (one SPI clock period) between frames. The SPI clock idles low whenever chip select is high. MOSI changes on falling SPI clock edges and MISO is sampled on rising ones.
- R9: `done` is a single-cycle pulse at the end of each completed write or read. `busy` is high from the cycle after a start until the operation ends.
- R10: After reset, chip select is high, the SPI clock is low, and `busy`, `done` and `full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Start storing a block (sampled while idle) |
| wr_len | input | LEN_W | Block length in bytes |
| wr_idx | output | LEN_W | Index of the block byte wanted now |
| wr_byte | input | 8 | Block byte at `wr_idx`, combinational |
| rd_start | input | 1 | Start a read (sampled while idle, write has priority) |
| rd_addr | input | 24 | Read start address |
| rd_len | input | LEN_W | Number of bytes to read |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |
| full | output | 1 | Block rejected for capacity pulse |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
The bench runs a chain of blocks whose lengths vary, with a small page and sector geometry, so that starts, ends and chunk edges fall on every kind of page and sector offset. A flash model programs only by ANDing bytes into memory and starts from all-zero contents. A missed erase or a program that crosses a page therefore corrupts the compared image, and a wrong split also shows as a wrong count of program frames. The model stays busy for several status reads and counts them, so a design that stops polling early, or that skips write-enable, is caught. The bench also checks the capacity edge: a block that overflows by one byte must leave no trace, and the block that then exactly fills the device must succeed.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  localparam int AW = 24;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;

  typedef enum logic [2:0] {FK_WREN, FK_ERASE, FK_PROG, FK_STAT, FK_READ} frame_kind_t;

  function automatic logic [7:0] kind_opcode(frame_kind_t k);
    case (k)
      FK_WREN:  return OP_WREN;
      FK_ERASE: return OP_ERASE;
      FK_PROG:  return OP_PROG;
      FK_STAT:  return OP_STAT;
      default:  return OP_READ;
    endcase
  endfunction

  // bytes that fit from addr up to the end of its page, capped by what is left
  function automatic logic [31:0] page_chunk(logic [31:0] addr, logic [31:0] left,
                                             logic [31:0] page);
    logic [31:0] room;
    room = page - (addr % page);
    return (left < room) ? left : room;
  endfunction

  function automatic logic on_sector_edge(logic [31:0] addr, logic [31:0] sector);
    return (addr % sector) == 32'd0;
  endfunction
endpackage

// File: rtl/sfw_spi_shifter.sv
module sfw_spi_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  logic [7:0] sh;
  logic [2:0] cnt;
  logic       act;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; act <= 1'b0; sclk <= 1'b0; done <= 1'b0; rx <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        sh <= tx; cnt <= '0; act <= 1'b1; sclk <= 1'b0;
      end else if (act) begin
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          sh   <= {sh[6:0], 1'b0};
          cnt  <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            act  <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfw_sequencer.sv
module sfw_sequencer
  import sfw_pkg::*;
#(
  parameter int LEN_W        = 12,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 4096,
  parameter int FLASH_BYTES  = 32'h400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [LEN_W-1:0]  wr_len,
  output logic [LEN_W-1:0]  wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic              rd_start,
  input  logic [AW-1:0]     rd_addr,
  input  logic [LEN_W-1:0]  rd_len,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              full,
  output logic              cs_n,
  output logic              go,
  output logic [7:0]        tx,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx,
  output logic              frm_start,
  output logic              frm_end,
  output frame_kind_t       frm_kind,
  output logic [AW-1:0]     frm_addr,
  output logic [LEN_W-1:0]  frm_chunk
);
  localparam int BW = LEN_W + 1;
  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} st_t;

  st_t               st;
  frame_kind_t       kind, pend;
  logic              fin, is_read, gcnt;
  logic [AW-1:0]     wptr, raddr, cur, faddr;
  logic [LEN_W-1:0]  blen, off, rlen, chunk;
  logic [BW-1:0]     bidx, flen;
  logic [31:0]       nxt;

  assign cur    = wptr + AW'(off);
  assign chunk  = LEN_W'(page_chunk(32'(cur), 32'(blen - off), 32'(PAGE_BYTES)));
  assign nxt    = 32'(cur) + 32'(chunk);
  assign faddr  = (kind == FK_READ) ? raddr : cur;
  assign wr_idx = off + LEN_W'(bidx - BW'(4));
  assign busy   = (st != S_IDLE);

  always_comb begin
    case (kind)
      FK_WREN:  flen = BW'(1);
      FK_ERASE: flen = BW'(4);
      FK_PROG:  flen = BW'(chunk) + BW'(4);
      FK_STAT:  flen = BW'(2);
      default:  flen = BW'(rlen) + BW'(4);
    endcase
  end

  always_comb begin
    if (bidx == BW'(0))      tx = kind_opcode(kind);
    else if (bidx == BW'(1)) tx = faddr[23:16];
    else if (bidx == BW'(2)) tx = faddr[15:8];
    else if (bidx == BW'(3)) tx = faddr[7:0];
    else                     tx = (kind == FK_PROG) ? wr_byte : 8'h00;
  end

  assign frm_start = go && (bidx == BW'(0));
  assign frm_end   = eng_done && (st == S_FRAME) && (bidx == flen - BW'(1));
  assign frm_kind  = kind;
  assign frm_addr  = cur;
  assign frm_chunk = chunk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= FK_WREN; pend <= FK_PROG; fin <= 1'b0; is_read <= 1'b0;
      gcnt <= 1'b0; wptr <= '0; raddr <= '0; blen <= '0; off <= '0; rlen <= '0;
      bidx <= '0; cs_n <= 1'b1; go <= 1'b0; done <= 1'b0; full <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      go <= 1'b0; done <= 1'b0; full <= 1'b0; rd_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (wr_start) begin
            if (32'(wptr) + 32'(wr_len) > 32'(FLASH_BYTES)) full <= 1'b1;
            else if (wr_len == '0) done <= 1'b1;
            else begin
              blen <= wr_len; off <= '0; is_read <= 1'b0; fin <= 1'b0; kind <= FK_WREN;
              pend <= on_sector_edge(32'(wptr), 32'(SECTOR_BYTES)) ? FK_ERASE : FK_PROG;
              st <= S_FRAME; cs_n <= 1'b0; go <= 1'b1; bidx <= '0;
            end
          end else if (rd_start) begin
            if (rd_len == '0) done <= 1'b1;
            else begin
              raddr <= rd_addr; rlen <= rd_len; is_read <= 1'b1; fin <= 1'b0; kind <= FK_READ;
              st <= S_FRAME; cs_n <= 1'b0; go <= 1'b1; bidx <= '0;
            end
          end
        end
        S_FRAME: begin
          if (eng_done) begin
            if (kind == FK_READ && bidx >= BW'(4)) begin
              rd_data <= eng_rx; rd_valid <= 1'b1;
            end
            if (bidx == flen - BW'(1)) begin
              cs_n <= 1'b1; st <= S_GAP; gcnt <= 1'b0;
              case (kind)
                FK_WREN:  kind <= pend;
                FK_ERASE: begin kind <= FK_STAT; pend <= FK_PROG; end
                FK_PROG: begin
                  kind <= FK_STAT;
                  off  <= off + chunk;
                  pend <= on_sector_edge(nxt, 32'(SECTOR_BYTES)) ? FK_ERASE : FK_PROG;
                end
                FK_STAT: if (!eng_rx[0]) begin
                  if (off == blen) fin <= 1'b1;
                  else kind <= FK_WREN;
                end
                default: fin <= 1'b1;
              endcase
            end else begin
              bidx <= bidx + BW'(1); go <= 1'b1;
            end
          end
        end
        default: begin
          if (!gcnt) gcnt <= 1'b1;
          else if (fin) begin
            st <= S_IDLE; done <= 1'b1;
            if (!is_read) wptr <= cur;
          end else begin
            st <= S_FRAME; cs_n <= 1'b0; go <= 1'b1; bidx <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sfw_block_writer.sv
module sfw_block_writer
  import sfw_pkg::*;
#(
  parameter int LEN_W        = 12,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 4096,
  parameter int FLASH_BYTES  = 32'h400000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic [LEN_W-1:0] wr_len,
  output logic [LEN_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             rd_start,
  input  logic [23:0]      rd_addr,
  input  logic [LEN_W-1:0] rd_len,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             full,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  logic             eng_go, eng_done;
  logic [7:0]       eng_tx, eng_rx;
  logic             frm_start, frm_end;
  frame_kind_t      frm_kind;
  logic [AW-1:0]    frm_addr;
  logic [LEN_W-1:0] frm_chunk;

  sfw_sequencer #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .FLASH_BYTES(FLASH_BYTES)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .wr_start(wr_start), .wr_len(wr_len), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .rd_start(rd_start), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .full(full), .cs_n(spi_cs_n),
    .go(eng_go), .tx(eng_tx), .eng_done(eng_done), .eng_rx(eng_rx),
    .frm_start(frm_start), .frm_end(frm_end), .frm_kind(frm_kind),
    .frm_addr(frm_addr), .frm_chunk(frm_chunk)
  );

  sfw_spi_shifter shf_i (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(eng_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(eng_done), .rx(eng_rx)
  );
endmodule

// File: rtl/sfw_block_writer_chk.sv
module sfw_block_writer_chk
  import sfw_pkg::*;
#(
  parameter int LEN_W        = 12,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 4096
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_start,
  input logic             frm_end,
  input frame_kind_t      frm_kind,
  input logic [AW-1:0]    frm_addr,
  input logic [LEN_W-1:0] frm_chunk,
  input logic [7:0]       frm_rx,
  input logic             spi_cs_n,
  input logic             spi_sclk,
  input logic             busy,
  input logic             done,
  input logic             full
);
  frame_kind_t last_kind;
  logic        stat_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_kind <= FK_STAT; stat_busy <= 1'b0;
    end else if (frm_end) begin
      last_kind <= frm_kind;
      if (frm_kind == FK_STAT) stat_busy <= frm_rx[0];
    end
  end

  p_wren_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start && (frm_kind == FK_ERASE || frm_kind == FK_PROG) |-> last_kind == FK_WREN);

  p_page_fit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start && frm_kind == FK_PROG |->
      frm_chunk != '0 &&
      (32'(frm_addr) % 32'(PAGE_BYTES)) + 32'(frm_chunk) <= 32'(PAGE_BYTES));

  p_erase_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start && frm_kind == FK_ERASE |-> (32'(frm_addr) % 32'(SECTOR_BYTES)) == 32'd0);

  p_poll_until_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start && stat_busy |-> frm_kind == FK_STAT);

  p_full_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !busy && spi_cs_n);

  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sfw_block_writer sfw_block_writer_chk #(
  .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
  .frm_kind(frm_kind), .frm_addr(frm_addr), .frm_chunk(frm_chunk), .frm_rx(eng_rx),
  .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .busy(busy), .done(done), .full(full)
);

// File: tb/sfw_block_writer_tb_top.sv
module sfw_block_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW  = 10;
  localparam int PG  = 16;
  localparam int SEC = 64;
  localparam int FSZ = 512;
  localparam int ERASE_POLLS = 3;
  localparam int PROG_POLLS  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_start = 1'b0, rd_start = 1'b0;
  logic [LW-1:0] wr_len = '0, rd_len = '0, wr_idx;
  logic [23:0] rd_addr = '0;
  logic [7:0] wr_byte, rd_data;
  logic rd_valid, busy, done, full, spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int tests = 0, fails = 0, cur_blk = 0;
  bit finished = 0;

  function automatic logic [7:0] pat(int b, int i);
    return 8'((b * 37 + i * 11 + 5) & 255);
  endfunction

  assign wr_byte = pat(cur_blk, int'(wr_idx));

  sfw_block_writer #(.LEN_W(LW), .PAGE_BYTES(PG), .SECTOR_BYTES(SEC), .FLASH_BYTES(FSZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_len(wr_len), .wr_idx(wr_idx),
    .wr_byte(wr_byte), .rd_start(rd_start), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .full(full),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- flash model ----------------
  logic [7:0] fmem [0:FSZ-1];
  logic [7:0] expm [0:FSZ-1];
  logic [7:0] fb [0:79];
  logic [7:0] sh = '0;
  int bits = 0, nbytes = 0, busy_cnt = 0, first_addr = -1;
  bit wel = 0;
  int n_wren, n_erase, n_prog, n_stat, n_read, n_frames;
  int err_wel, err_busy, err_page, err_unerased, err_gap;

  always @(negedge spi_cs_n) begin bits = 0; nbytes = 0; spi_miso = 1'b0; end

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bits++;
    if (bits % 8 == 0) begin
      if (nbytes < 80) fb[nbytes] = sh;
      nbytes++;
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    int by, bt, a;
    logic [7:0] v;
    by = bits / 8; bt = bits % 8; v = 8'h00;
    a = int'({fb[1], fb[2], fb[3]});
    if (by >= 1 && fb[0] == 8'h05) v = {7'd0, busy_cnt != 0};
    if (by >= 4 && fb[0] == 8'h03) v = fmem[(a + by - 4) % FSZ];
    spi_miso = v[7 - bt];
  end

  always @(posedge spi_cs_n) if (nbytes > 0) begin
    int a, d;
    logic [7:0] op;
    op = fb[0]; a = int'({fb[1], fb[2], fb[3]});
    n_frames++;
    if (op != 8'h05 && busy_cnt != 0) err_busy++;
    if ((op == 8'h20 || op == 8'h02) && first_addr < 0) first_addr = a;
    case (op)
      8'h06: begin n_wren++; wel = 1; end
      8'h20: begin
        n_erase++;
        if (!wel) err_wel++;
        for (int i = 0; i < SEC; i++) fmem[((a / SEC) * SEC + i) % FSZ] = 8'hFF;
        wel = 0; busy_cnt = ERASE_POLLS;
      end
      8'h02: begin
        n_prog++;
        if (!wel) err_wel++;
        d = nbytes - 4;
        if (d < 1 || (a % PG) + d > PG) err_page++;
        for (int i = 0; i < d; i++) begin
          if (fmem[(a + i) % FSZ] != 8'hFF) err_unerased++;
          fmem[(a + i) % FSZ] = fmem[(a + i) % FSZ] & fb[4 + i];
        end
        wel = 0; busy_cnt = PROG_POLLS;
      end
      8'h05: begin n_stat++; if (busy_cnt > 0) busy_cnt--; end
      8'h03: n_read++;
      default: err_busy++;
    endcase
  end

  // ---------------- port monitors (away from the active edge) ----------------
  int done_cnt, full_cnt, rcnt, hi_cnt = 0;
  logic [7:0] rbuf [0:63];
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (full) full_cnt++;
    if (rd_valid) begin if (rcnt < 64) rbuf[rcnt] = rd_data; rcnt++; end
    if (spi_cs_n) hi_cnt++;
    else begin
      if (hi_cnt > 0 && hi_cnt < 2) err_gap++;
      hi_cnt = 0;
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_stats();
    n_wren = 0; n_erase = 0; n_prog = 0; n_stat = 0; n_read = 0; n_frames = 0;
    done_cnt = 0; full_cnt = 0; rcnt = 0; first_addr = -1;
  endtask

  task automatic do_write(int p, int n, bit expect_ok);
    int e, pr;
    clear_stats();
    @(negedge clk); wr_len = LW'(n); wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
    if (expect_ok && n > 0) check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    while (done_cnt == 0 && full_cnt == 0) @(negedge clk);
    repeat (6) @(negedge clk);
    if (!expect_ok) begin
      check(full_cnt == 1, "R6 full pulse", full_cnt, 1);
      check(done_cnt == 0 && n_frames == 0, "R6 no frames on reject", n_frames, 0);
      return;
    end
    check(done_cnt == 1 && full_cnt == 0, "R9 single done pulse", done_cnt, 1);
    if (n == 0) begin
      check(n_frames == 0, "R5 zero-length block", n_frames, 0);
      return;
    end
    e  = ((p + n + SEC - 1) / SEC) - ((p + SEC - 1) / SEC);
    pr = (p + n - 1) / PG - p / PG + 1;
    check(first_addr == p, "R5 block starts at pointer", first_addr, p);
    check(n_erase == e, "R3 erase count", n_erase, e);
    check(n_prog == pr, "R2 program count", n_prog, pr);
    check(n_wren == e + pr, "R1 write-enable count", n_wren, e + pr);
    check(n_stat == (ERASE_POLLS + 1) * e + (PROG_POLLS + 1) * pr, "R4 status poll count",
          n_stat, (ERASE_POLLS + 1) * e + (PROG_POLLS + 1) * pr);
    for (int i = 0; i < n; i++) begin
      if ((p + i) % SEC == 0) for (int j = 0; j < SEC; j++) expm[p + i + j] = 8'hFF;
      expm[p + i] = pat(cur_blk, i);
    end
  endtask

  task automatic do_read(int a, int n);
    int bad;
    clear_stats();
    @(negedge clk); rd_addr = 24'(a); rd_len = LW'(n); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(n_read == 1 && n_frames == 1, "R7 single read frame", n_read, 1);
    check(rcnt == n, "R7 read byte count", rcnt, n);
    bad = 0;
    for (int i = 0; i < n && i < 64; i++) if (rbuf[i] !== expm[a + i]) bad++;
    check(bad == 0, "R7 read data", bad, 0);
  endtask

  initial begin
    int p, n, k, bad;
    for (int i = 0; i < FSZ; i++) begin fmem[i] = 8'h00; expm[i] = 8'h00; end
    err_wel = 0; err_busy = 0; err_page = 0; err_unerased = 0; err_gap = 0;
    clear_stats();
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R10 SPI idle in reset", int'(spi_cs_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !full, "R10 status low after reset", int'(busy), 0);

    p = 0;
    cur_blk = 1; do_write(p, 40, 1); p += 40;     // spans three pages
    cur_blk = 2; do_write(p, 50, 1); p += 50;     // crosses a sector edge mid-block
    cur_blk = 3; do_write(p, 1, 1);  p += 1;
    cur_blk = 4; do_write(p, 0, 1);               // zero length
    k = 0;
    n = 1 + (k * 13) % 70;
    while (p + n <= FSZ - 8) begin
      cur_blk = 10 + k; do_write(p, n, 1); p += n;
      k++; n = 1 + (k * 13) % 70;
    end
    cur_blk = 99; do_write(p, FSZ - p + 1, 0);     // overflow by one byte
    cur_blk = 100; do_write(p, FSZ - p, 1); p = FSZ; // ends exactly at limit
    cur_blk = 101; do_write(p, 1, 0);

    bad = 0;
    for (int i = 0; i < FSZ; i++) if (fmem[i] !== expm[i]) bad++;
    check(bad == 0, "R2 R3 stored image", bad, 0);
    check(err_wel == 0, "R1 program or erase without write-enable", err_wel, 0);
    check(err_page == 0, "R2 program crossed a page", err_page, 0);
    check(err_unerased == 0, "R3 program onto unerased byte", err_unerased, 0);
    check(err_busy == 0, "R4 command while busy", err_busy, 0);

    do_read(0, 5);
    do_read(30, 20);
    do_read(60, 40);
    do_read(500, 12);
    check(err_gap == 0, "R8 chip-select gap", err_gap, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule